// File: doc/BRIEF.md
# SLIP Packet Framer and Deframer

This block turns a byte stream that carries SLIP-framed packets into stored packets, and turns a stored packet back into a framed byte stream. Both byte streams use a valid/ready handshake. A shared single-port packet buffer sits between the two sides, so a packet that has been deframed can be sent out again by giving the transmit side its length. The result is a packet bridge between two byte links. Line coding, character timing and medium arbitration are handled outside the block.

The receive side waits for a delimiter byte, removes escape sequences, writes payload bytes into the buffer from address 0 upward, and pulses a done flag with the payload length when the closing delimiter arrives. A packet that would grow past the buffer's length range, or that goes quiet for longer than the idle window, is dropped and reported with length zero. The transmit side takes a start pulse and a length. It sends a delimiter, then the buffer contents from address 0 with escape substitution, then a closing delimiter, and it holds busy for the whole time.

Top module: `slip_codec`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, tx_valid, tx_busy and rx_done are 0 and rx_ready is 1.
- R2: While no packet is open, every accepted byte other than the delimiter 0xC0 is dropped without effect. Reception opens only on an accepted 0xC0.
- R3: Inside a packet, the pair 0xDB 0xDD stores 0xDB, and 0xDB followed by any other byte stores 0xC0. Bytes other than 0xC0 and 0xDB are stored unchanged at consecutive addresses from 0.
- R4: An unescaped 0xC0 inside a packet closes it. rx_done is high for exactly one cycle, on the cycle after the closing byte is accepted, and rx_len then holds the number of stored payload bytes, not counting delimiters. Two delimiters back to back report length 0.
- R5: A packet may hold at most 2**LEN_W-1 payload bytes. The byte that would exceed this drops the packet at once, with rx_done and rx_len equal to 0.
- R6: If an open packet goes more than 2**IDLE_W-1 cycles without an accepted byte, it is dropped with rx_done and rx_len equal to 0. A shorter gap has no effect.
- R7: After an accepted tx_start, the transmit stream is 0xC0, then the encoded buffer bytes at addresses 0 to tx_len-1 in address order, then 0xC0. A length of 0 gives 0xC0 0xC0.
- R8: When transmitted, a payload byte 0xC0 becomes 0xDB 0xDC and a payload byte 0xDB becomes 0xDB 0xDD. Every other byte passes through unchanged.
- R9: tx_data stays stable while tx_valid is high and tx_ready is low. tx_busy rises on the cycle after an accepted tx_start and falls on the cycle after the closing delimiter is accepted.
- R10: tx_start has no effect while tx_busy is high or while a received packet is open. rx_ready is low while tx_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_ready | output | 1 | Block can accept an incoming byte |
| rx_data | input | 8 | Incoming framed byte |
| rx_done | output | 1 | One-cycle pulse when a packet ends or is dropped |
| rx_len | output | LEN_W | Payload length of the finished packet, 0 when dropped |
| tx_start | input | 1 | Pulse to send the buffer contents |
| tx_len | input | LEN_W | Number of buffer bytes to send |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Downstream accepts the outgoing byte |
| tx_data | output | 8 | Outgoing framed byte |

## Verification
rx_done and rx_len are registered, so they are due on the cycle after the edge that accepts the closing or offending byte. The bench drives inputs just after a rising edge and reads the pulse at the following falling edge, then confirms it has cleared one falling edge later. Transmit bytes are compared at the falling edge before the edge that completes their handshake, against a queue that the driver fills from the escaping rule. tx_busy is checked at the first falling edge after the start edge. The idle window is exercised with gaps on each side of 2**IDLE_W cycles, using a reduced IDLE_W.

// File: rtl/slip_pkg.sv
// Shared constants and state types for the SLIP framer/deframer.
// Assumes 8-bit characters; the four special byte values are fixed by the framing.
package slip_pkg;
    localparam logic [7:0] DELIM_B    = 8'hC0;
    localparam logic [7:0] ESCAPE_B   = 8'hDB;
    localparam logic [7:0] ESC_DELIM  = 8'hDC;
    localparam logic [7:0] ESC_ESCAPE = 8'hDD;

    typedef enum logic [1:0] {RX_HUNT, RX_BODY, RX_ESC} rx_state_t;
    typedef enum logic [2:0] {TX_IDLE, TX_OPEN, TX_READ, TX_DATA, TX_ESC2, TX_CLOSE} tx_state_t;
endpackage

// File: rtl/slip_buf.sv
// Packet buffer: synchronous single-port array, one access per cycle.
// Assumes the caller never needs a read and a write in the same cycle.
module slip_buf #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Write on enable, otherwise register the addressed word.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        else    rdata     <= mem[addr];
    end
endmodule

// File: rtl/slip_rx.sv
// Deframer: hunts for a delimiter, removes escaping, writes payload bytes
// sequentially from address 0 and reports the length on a one-cycle done.
// Overflow or an idle gap drops the packet with length 0.
// Assumes in_ready is supplied by the top and only gates acceptance.
module slip_rx #(
    parameter int LEN_W  = 8,
    parameter int IDLE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             done,
    output logic [LEN_W-1:0] len,
    output logic             hunting
);
    import slip_pkg::*;

    localparam logic [LEN_W-1:0]  CNT_MAX  = {LEN_W{1'b1}};
    localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};
    localparam logic [LEN_W-1:0]  CNT_ONE  = 1;
    localparam logic [IDLE_W-1:0] IDLE_ONE = 1;

    rx_state_t         st;
    logic [LEN_W-1:0]  cnt;
    logic [IDLE_W-1:0] idle;
    logic              accept, store, overflow, timeout;

    // Decode the accepted byte into a store request and the abort conditions.
    always_comb begin
        accept   = in_valid && in_ready;
        store    = accept && ((st == RX_ESC) ||
                   (st == RX_BODY && in_data != DELIM_B && in_data != ESCAPE_B));
        overflow = store && (cnt == CNT_MAX);
        timeout  = (st != RX_HUNT) && !accept && (idle == IDLE_MAX);
        wr_en    = store && !overflow;
        wr_addr  = cnt;
        if (st == RX_ESC) wr_data = (in_data == ESC_ESCAPE) ? ESCAPE_B : DELIM_B;
        else              wr_data = in_data;
        hunting  = (st == RX_HUNT);
    end

    // Packet state, byte count, idle counter and done/length reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_HUNT;
            cnt  <= '0;
            idle <= '0;
            done <= 1'b0;
            len  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_HUNT: begin
                    if (accept && in_data == DELIM_B) begin
                        st   <= RX_BODY;
                        cnt  <= '0;
                        idle <= '0;
                    end
                end
                RX_BODY, RX_ESC: begin
                    if (timeout || overflow) begin
                        done <= 1'b1;
                        len  <= '0;
                        st   <= RX_HUNT;
                    end else if (accept) begin
                        idle <= '0;
                        if (st == RX_BODY && in_data == DELIM_B) begin
                            done <= 1'b1;
                            len  <= cnt;
                            st   <= RX_HUNT;
                        end else if (st == RX_BODY && in_data == ESCAPE_B) begin
                            st <= RX_ESC;
                        end else begin
                            cnt <= cnt + CNT_ONE;
                            st  <= RX_BODY;
                        end
                    end else begin
                        idle <= idle + IDLE_ONE;
                    end
                end
                default: st <= RX_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/slip_tx.sv
// Framer: sends a delimiter, the buffer bytes 0..n-1 with escape substitution,
// then a closing delimiter. Reads the buffer one cycle ahead of each byte.
// Assumes go is only raised when the framer is idle.
module slip_tx #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] n_bytes,
    input  logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_addr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             busy
);
    import slip_pkg::*;

    localparam logic [LEN_W-1:0] IDX_ONE = 1;

    tx_state_t        st;
    logic [LEN_W-1:0] idx, n_q;
    logic             hs, special, last;

    // Output byte selection and handshake decode.
    always_comb begin
        special   = (rd_data == DELIM_B) || (rd_data == ESCAPE_B);
        last      = ((idx + IDX_ONE) == n_q);
        out_valid = (st == TX_OPEN) || (st == TX_DATA) || (st == TX_ESC2) || (st == TX_CLOSE);
        hs        = out_valid && out_ready;
        busy      = (st != TX_IDLE);
        rd_addr   = idx;
        case (st)
            TX_DATA:  out_data = special ? ESCAPE_B : rd_data;
            TX_ESC2:  out_data = (rd_data == DELIM_B) ? ESC_DELIM : ESC_ESCAPE;
            default:  out_data = DELIM_B;
        endcase
    end

    // Frame sequencer: open, read/send each byte, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TX_IDLE;
            idx <= '0;
            n_q <= '0;
        end else begin
            case (st)
                TX_IDLE: if (go) begin
                    n_q <= n_bytes;
                    idx <= '0;
                    st  <= TX_OPEN;
                end
                TX_OPEN:  if (hs) st <= (n_q == '0) ? TX_CLOSE : TX_READ;
                TX_READ:  st <= TX_DATA;
                TX_DATA, TX_ESC2: if (hs) begin
                    if (st == TX_DATA && special) begin
                        st <= TX_ESC2;
                    end else if (last) begin
                        st <= TX_CLOSE;
                    end else begin
                        idx <= idx + IDX_ONE;
                        st  <= TX_READ;
                    end
                end
                TX_CLOSE: if (hs) st <= TX_IDLE;
                default:  st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slip_codec.sv
// Top: SLIP deframer and framer sharing one single-port packet buffer.
// The receive side owns the buffer unless a transmit frame is in progress;
// a transmit start is taken only while no received packet is open.
module slip_codec #(
    parameter int LEN_W  = 8,
    parameter int IDLE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    output logic             rx_done,
    output logic [LEN_W-1:0] rx_len,
    input  logic             tx_start,
    input  logic [LEN_W-1:0] tx_len,
    output logic             tx_busy,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data
);
    logic             rx_hunting, wr_en, tx_go;
    logic [LEN_W-1:0] wr_addr, rd_addr, buf_addr;
    logic [7:0]       wr_data, rd_data;

    // Buffer ownership and start qualification.
    always_comb begin
        tx_go    = tx_start && !tx_busy && rx_hunting;
        rx_ready = !tx_busy && !tx_go;
        buf_addr = tx_busy ? rd_addr : wr_addr;
    end

    slip_rx #(.LEN_W(LEN_W), .IDLE_W(IDLE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_ready(rx_ready), .in_data(rx_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(rx_done), .len(rx_len), .hunting(rx_hunting)
    );

    slip_buf #(.AW(LEN_W)) u_buf (
        .clk(clk), .we(wr_en), .addr(buf_addr), .wdata(wr_data), .rdata(rd_data)
    );

    slip_tx #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .n_bytes(tx_len),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data),
        .busy(tx_busy)
    );
endmodule

// File: rtl/slip_codec_chk.sv
// Protocol checker for slip_codec, attached to every instance by bind.
module slip_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_ready,
    input logic       rx_done,
    input logic       tx_busy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data
);
    // R1: reset clears the outputs by the next cycle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!tx_busy && !tx_valid && !rx_done));

    // R4: done is a single-cycle pulse.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R7: bytes are only offered inside a frame.
    p_valid_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_busy);

    // R8: an escape byte is followed at once by its partner code.
    p_escape_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_data == 8'hDB) |=>
        (tx_valid && (tx_data == 8'hDC || tx_data == 8'hDD)));

    // R9: a stalled byte is held unchanged.
    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10: receive is closed while a frame is being sent.
    p_rx_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_ready);
endmodule

bind slip_codec slip_codec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_done(rx_done),
    .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/test_slip_codec.sv
// Scoreboard bench: driver tasks queue expected transmit bytes and receive
// lengths; a monitor at each falling edge pops and compares them.
module test_slip_codec;
    localparam int LEN_W  = 8;
    localparam int IDLE_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_valid, rx_ready, rx_done;
    logic [7:0]       rx_data;
    logic [LEN_W-1:0] rx_len;
    logic             tx_start, tx_busy, tx_valid;
    logic             tx_ready = 1'b1;
    logic [LEN_W-1:0] tx_len;
    logic [7:0]       tx_data;

    int checks = 0, fails = 0;
    logic [7:0] model [256];
    logic [7:0] exp_tx [$];
    int         exp_len [$];
    string      exp_tag [$];
    bit         stall_en = 1'b0;
    int         stall_cnt = 0;
    logic [7:0] held;
    bit         held_v = 1'b0;

    always #10 clk = ~clk;

    slip_codec #(.LEN_W(LEN_W), .IDLE_W(IDLE_W)) i_slip_codec (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_done(rx_done), .rx_len(rx_len),
        .tx_start(tx_start), .tx_len(tx_len), .tx_busy(tx_busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Downstream ready pattern: stalls one cycle in three when enabled.
    always @(posedge clk) begin
        #1;
        stall_cnt++;
        tx_ready = !stall_en || (stall_cnt % 3 != 0);
    end

    // Monitor: compare produced bytes and lengths against the queues.
    always @(negedge clk) begin : mon
        logic [7:0] e;
        int l;
        string t;
        if (rst_n) begin
            if (held_v) chk(tx_valid && tx_data == held, "R9 stalled byte held", tx_data, held);
            held_v = tx_valid && !tx_ready;
            held   = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk(1'b0, "R7 unexpected tx byte", tx_data, 0);
                else begin
                    e = exp_tx.pop_front();
                    chk(tx_data == e, "R7 R8 tx byte", tx_data, e);
                end
            end
            if (rx_done) begin
                if (exp_len.size() == 0) chk(1'b0, "R2 unexpected rx_done", rx_len, 0);
                else begin
                    l = exp_len.pop_front();
                    t = exp_tag.pop_front();
                    chk(int'(rx_len) == l, t, rx_len, l);
                end
            end
        end
    end

    task automatic put_rx(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] s [$]);
        foreach (s[i]) put_rx(s[i]);
    endtask

    // Expect a packet result; a kept packet also defines the buffer model.
    task automatic expect_pkt(input int n, input logic [7:0] p [$], input string tag);
        exp_len.push_back(n);
        exp_tag.push_back(tag);
        for (int i = 0; i < n; i++) model[i] = p[i];
    endtask

    task automatic do_tx(input int n, input bit extra);
        exp_tx.push_back(8'hC0);
        for (int i = 0; i < n; i++) begin
            if (model[i] == 8'hC0)      begin exp_tx.push_back(8'hDB); exp_tx.push_back(8'hDC); end
            else if (model[i] == 8'hDB) begin exp_tx.push_back(8'hDB); exp_tx.push_back(8'hDD); end
            else exp_tx.push_back(model[i]);
        end
        exp_tx.push_back(8'hC0);
        tx_len   = LEN_W'(n);
        tx_start = 1'b1;
        @(posedge clk); #1;
        tx_start = 1'b0;
        @(negedge clk);
        chk(tx_busy == 1'b1, "R9 busy after start", tx_busy, 1);
        chk(rx_ready == 1'b0, "R10 rx_ready low while busy", rx_ready, 0);
        if (extra) begin
            @(posedge clk); #1;
            tx_len   = 8'd1;
            tx_start = 1'b1;
            @(posedge clk); #1;
            tx_start = 1'b0;
        end
        while (tx_busy) @(negedge clk);
        chk(exp_tx.size() == 0, "R7 frame complete at busy fall", exp_tx.size(), 0);
        @(posedge clk); #1;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : drv
        logic [7:0] raw [$];
        logic [7:0] pay [$];
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; tx_start = 1'b0; tx_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_valid && !tx_busy && !rx_done, "R1 outputs idle in reset", {tx_valid, tx_busy, rx_done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !tx_busy && !rx_done && rx_ready, "R1 state after reset",
            {tx_valid, tx_busy, rx_done, rx_ready}, 1);
        @(posedge clk); #1;
        stall_en = 1'b1;

        // R2: bytes before the delimiter are dropped.
        send('{8'h11, 8'h22, 8'hDB, 8'h44});
        @(negedge clk);
        chk(rx_done == 1'b0, "R2 no result from stray bytes", rx_done, 0);
        @(posedge clk); #1;
        pay = '{8'h01, 8'h02, 8'h03};
        expect_pkt(3, pay, "R4 length of plain packet");
        send('{8'hC0, 8'h01, 8'h02, 8'h03, 8'hC0});
        @(negedge clk);
        chk(rx_done && rx_len == 3, "R4 done on cycle after close", rx_len, 3);
        @(negedge clk);
        chk(rx_done == 1'b0, "R4 done lasts one cycle", rx_done, 0);
        @(posedge clk); #1;
        do_tx(3, 1'b0);                                      // R7

        // R3 / R8: escape decoding and re-encoding.
        pay = '{8'h10, 8'hDB, 8'hC0, 8'hC0, 8'h20};
        expect_pkt(5, pay, "R3 length of escaped packet");
        send('{8'hC0, 8'h10, 8'hDB, 8'hDD, 8'hDB, 8'hDC, 8'hDB, 8'h41, 8'h20, 8'hC0});
        do_tx(5, 1'b1);                                      // R8, R10 start ignored while busy

        // R4 / R7: empty packet and empty frame.
        pay = '{};
        expect_pkt(0, pay, "R4 empty packet length");
        send('{8'hC0, 8'hC0});
        do_tx(0, 1'b0);

        // R6: idle timeout drops, shorter gap does not.
        expect_pkt(0, pay, "R6 timeout reports zero");
        send('{8'hC0, 8'hAA, 8'hBB});
        repeat (300) @(posedge clk); #1;
        chk(exp_len.size() == 0, "R6 timeout result seen", exp_len.size(), 0);
        pay = '{8'h07, 8'h08};
        expect_pkt(2, pay, "R6 gap below window keeps packet");
        send('{8'hC0, 8'h07});
        repeat (200) @(posedge clk); #1;
        send('{8'h08, 8'hC0});
        do_tx(2, 1'b0);

        // R5: overflow at 2**LEN_W payload bytes, full packet just below.
        expect_pkt(0, pay, "R5 overflow reports zero");
        raw = '{8'hC0};
        for (int i = 0; i < 256; i++) raw.push_back(8'(i % 100));
        send(raw);
        repeat (3) @(posedge clk); #1;
        chk(exp_len.size() == 0, "R5 overflow result seen", exp_len.size(), 0);
        raw = '{8'hC0};
        pay = '{};
        for (int i = 0; i < 255; i++) begin raw.push_back(8'(i % 100)); pay.push_back(8'(i % 100)); end
        raw.push_back(8'hC0);
        expect_pkt(255, pay, "R5 largest packet kept");
        send(raw);
        do_tx(255, 1'b0);

        // R10: start ignored while a received packet is open.
        pay = '{8'h55, 8'h66};
        expect_pkt(2, pay, "R10 packet intact after ignored start");
        send('{8'hC0, 8'h55});
        tx_len   = 8'd2;
        tx_start = 1'b1;
        @(posedge clk); #1;
        tx_start = 1'b0;
        @(negedge clk);
        chk(tx_busy == 1'b0, "R10 start ignored mid-packet", tx_busy, 0);
        @(posedge clk); #1;
        send('{8'h66, 8'hC0});
        do_tx(2, 1'b0);

        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(exp_len.size() == 0 && exp_tx.size() == 0, "R4 R7 all results delivered",
            exp_len.size() + exp_tx.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule